// File: doc/BRIEF.md
# Bus Cycle Response Timeout Monitor

This block watches every bus cycle that the local master starts and raises a bus error when no termination response comes back within a programmable number of system clocks. A cycle begins with a one-clock start pulse that carries the cycle type (interrupt acknowledge or normal) and the target (an internal module or the external bus). The block then counts clocks until a response ends the cycle. If the count reaches the selected limit first, it drives a one-clock bus error pulse.

For a normal cycle, a data acknowledge, a bus error response or a halt response ends the cycle. An autovector response also ends the cycle, but only during an interrupt acknowledge cycle. Cycles to internal modules are always monitored. Cycles that go out to the external bus are monitored only when the external enable is set and the local device holds bus mastership.

The external enable and a two-bit limit selector live in a small configuration register. Software loads this register with a write strobe. The register settings are sampled at each cycle start and hold for that whole cycle.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: After reset, bus_err is low, the external enable reads as 1 and the limit selector reads as 00, so an unterminated cycle times out after 64 clocks.
- R2: The limit selector encodes 00 = 64, 01 = 32, 10 = 16 and 11 = 8 clocks. If the start pulse is sampled at clock edge 0 and no response follows, bus_err is high just after edge N, where N is the selected limit.
- R3: Any one of rsp_ack, rsp_err or rsp_halt sampled at an edge from 1 to N ends the cycle without a bus error. A response sampled at edge N still wins over the timeout.
- R4: rsp_avec ends the cycle only when cyc_iack was 1 at the start. In a normal cycle, rsp_avec is ignored and the cycle still times out.
- R5: A cycle with cyc_ext = 0 is monitored whatever the values of the external enable and local_master. This holds even if local_master drops during the cycle.
- R6: A cycle with cyc_ext = 1 is monitored only if the external enable is 1 and local_master is 1 when the cycle starts. Otherwise it never raises bus_err.
- R7: If local_master falls during a monitored external cycle, monitoring of that cycle stops and no bus error is raised for it.
- R8: bus_err lasts exactly one clock. At most one pulse is issued per cycle, and no pulse comes while no cycle is being watched.
- R9: A new start pulse during a watched cycle restarts the count from zero. The next timeout then falls N edges after the new start.
- R10: The limit and the external enable are sampled at cycle start. A configuration write during a cycle does not change the timeout of that cycle.
- R11: When cfg_wr is high, cfg_ext_en and cfg_limit_sel are loaded into the configuration register at that edge, and they apply from the next cycle start on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ext_en | input | 1 | New value of the external-cycle monitoring enable |
| cfg_limit_sel | input | 2 | New limit selector (00=64, 01=32, 10=16, 11=8) |
| cyc_start | input | 1 | One-clock pulse at the start of a bus cycle |
| cyc_iack | input | 1 | Cycle is an interrupt acknowledge (valid with cyc_start) |
| cyc_ext | input | 1 | Cycle targets the external bus (valid with cyc_start) |
| local_master | input | 1 | Local device currently owns the external bus |
| rsp_ack | input | 1 | Data transfer acknowledge response |
| rsp_err | input | 1 | Bus error response |
| rsp_halt | input | 1 | Halt response |
| rsp_avec | input | 1 | Autovector response |
| bus_err | output | 1 | One-clock timeout bus error pulse |

## Verification
A counter that is off by one moves the bus_err edge one clock away from the computed limit. Likewise, a wrong entry in the limit decode moves the pulse to one of the other limits. Both faults show within 64 clocks of the first unanswered cycle. A stuck active flag or a wrong monitoring decision shows up as a pulse that should not be there, or as one that is missing. A wrong response decode does the same, for example an autovector that is honoured in a normal cycle. These faults are visible in the same cycle window. A failure to latch the settings at cycle start shows up only when a configuration write lands inside a running cycle, so one directed case places it there.

// File: rtl/bcw_pkg.sv
package bcw_pkg;

  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic             ext_en;
    logic [SEL_W-1:0] sel;
  } bcw_cfg_t;

  // Timeout limit in clocks: the smallest limit shifted left by (3 - sel).
  function automatic int unsigned limit_of(input logic [SEL_W-1:0] sel,
                                           input int unsigned       min_limit);
    return min_limit << (32'd3 - 32'(sel));
  endfunction

endpackage

// File: rtl/bcw_cfg.sv
module bcw_cfg
  import bcw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  bcw_cfg_t cfg_d,
  output bcw_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.ext_en <= 1'b1;
      cfg_q.sel    <= '0;
    end else if (wr) begin
      cfg_q <= cfg_d;
    end
  end

  // R11: the register changes only on a write
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q));

endmodule

// File: rtl/bcw_qualify.sv
module bcw_qualify (
  input  logic cyc_ext,
  input  logic ext_en,
  input  logic master,
  input  logic iack_q,
  input  logic ext_q,
  input  logic rsp_ack,
  input  logic rsp_err,
  input  logic rsp_halt,
  input  logic rsp_avec,
  output logic mon_start,
  output logic term_hit,
  output logic keep
);

  // Internal cycles are always watched; external ones need enable and mastership.
  assign mon_start = !cyc_ext || (ext_en && master);
  // Autovector ends the cycle only during interrupt acknowledge.
  assign term_hit  = rsp_ack || rsp_err || rsp_halt || (iack_q && rsp_avec);
  // An external cycle stops being watched once mastership is lost.
  assign keep      = !ext_q || master;

endmodule

// File: rtl/bcw_timer.sv
module bcw_timer
  import bcw_pkg::*;
#(
  parameter int unsigned MIN_LIMIT = 8,
  localparam int unsigned MAX_LIMIT = MIN_LIMIT << 3,
  localparam int unsigned CNT_W = $clog2(MAX_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mon_start,
  input  logic             iack_in,
  input  logic             ext_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             term_hit,
  input  logic             keep,
  output logic             active,
  output logic             iack_q,
  output logic             ext_q,
  output logic             err
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] count_nxt;
  logic             expire;

  assign count_nxt = count + 1'b1;
  assign expire    = active && !start && !term_hit && keep && (count_nxt == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
      lim_q  <= CNT_W'(limit_of('0, MIN_LIMIT));
      iack_q <= 1'b0;
      ext_q  <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= expire;
      if (start) begin
        active <= mon_start;
        count  <= '0;
        lim_q  <= CNT_W'(limit_of(sel_in, MIN_LIMIT));
        iack_q <= iack_in;
        ext_q  <= ext_in;
      end else if (active) begin
        if (term_hit || !keep || expire) active <= 1'b0;
        else                             count  <= count_nxt;
      end
    end
  end

  // R2: the count never reaches the limit while a cycle is watched
  p_count_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (count < lim_q));
  // R8: single-clock pulse
  p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  // R8: nothing is raised while no cycle is watched
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !err);
  // R3: a response ends the cycle without an error
  p_term_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && term_hit && !start) |=> (!err && !active));

endmodule

// File: rtl/bus_cycle_watchdog.sv
module bus_cycle_watchdog
  import bcw_pkg::*;
#(
  parameter int unsigned MIN_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_ext_en,
  input  logic [SEL_W-1:0] cfg_limit_sel,
  input  logic             cyc_start,
  input  logic             cyc_iack,
  input  logic             cyc_ext,
  input  logic             local_master,
  input  logic             rsp_ack,
  input  logic             rsp_err,
  input  logic             rsp_halt,
  input  logic             rsp_avec,
  output logic             bus_err
);

  bcw_cfg_t cfg_d, cfg_q;
  logic     mon_start, term_hit, keep;
  logic     active, iack_q, ext_q;

  assign cfg_d.ext_en = cfg_ext_en;
  assign cfg_d.sel    = cfg_limit_sel;

  bcw_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .cfg_d (cfg_d),
    .cfg_q (cfg_q)
  );

  bcw_qualify u_qual (
    .cyc_ext   (cyc_ext),
    .ext_en    (cfg_q.ext_en),
    .master    (local_master),
    .iack_q    (iack_q),
    .ext_q     (ext_q),
    .rsp_ack   (rsp_ack),
    .rsp_err   (rsp_err),
    .rsp_halt  (rsp_halt),
    .rsp_avec  (rsp_avec),
    .mon_start (mon_start),
    .term_hit  (term_hit),
    .keep      (keep)
  );

  bcw_timer #(.MIN_LIMIT(MIN_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cyc_start),
    .mon_start (mon_start),
    .iack_in   (cyc_iack),
    .ext_in    (cyc_ext),
    .sel_in    (cfg_q.sel),
    .term_hit  (term_hit),
    .keep      (keep),
    .active    (active),
    .iack_q    (iack_q),
    .ext_q     (ext_q),
    .err       (bus_err)
  );

  // R5: internal cycles are always watched
  p_internal_always_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_ext) |=> active);
  // R6: external cycles without enable and mastership are not watched
  p_ext_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && cyc_ext && !(cfg_q.ext_en && local_master)) |=> !active);
  // R7: losing mastership ends an external cycle quietly
  p_master_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ext_q && !local_master && !cyc_start) |=> (!active && !bus_err));
  // R4: autovector in a normal cycle is not a response
  p_avec_normal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !iack_q && rsp_avec && !rsp_ack && !rsp_err && !rsp_halt
     && keep && !cyc_start) |=> (active || bus_err));

endmodule

// File: tb/bus_cycle_watchdog_bench.sv
`timescale 1ns/1ps
module bus_cycle_watchdog_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_ext_en = 1'b0;
  logic [1:0] cfg_limit_sel = 2'b00;
  logic       cyc_start = 1'b0, cyc_iack = 1'b0, cyc_ext = 1'b0;
  logic       local_master = 1'b1;
  logic       rsp_ack = 1'b0, rsp_err = 1'b0, rsp_halt = 1'b0, rsp_avec = 1'b0;
  logic       bus_err;

  int n_run = 0, n_fail = 0, n_clk = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_cycle_watchdog u_bus_cycle_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext_en(cfg_ext_en),
    .cfg_limit_sel(cfg_limit_sel), .cyc_start(cyc_start), .cyc_iack(cyc_iack),
    .cyc_ext(cyc_ext), .local_master(local_master), .rsp_ack(rsp_ack),
    .rsp_err(rsp_err), .rsp_halt(rsp_halt), .rsp_avec(rsp_avec), .bus_err(bus_err)
  );

  // Limit restated from R2: 64 halved per selector step.
  function automatic int exp_limit(input logic [1:0] s);
    case (s)
      2'b00: return 64;
      2'b01: return 32;
      2'b10: return 16;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic en, input logic [1:0] s);
    @(negedge clk); cfg_wr = 1'b1; cfg_ext_en = en; cfg_limit_sel = s;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // tk: 0 none, 1 ack, 2 err, 3 halt, 4 avec, sampled at edge tat.
  // ek: 0 none, 1 drop mastership, 2 restart, 3 config write (en 0, sel 00), at edge eat.
  task automatic run(input logic iack, input logic ext, input int tk, input int tat,
                     input int ek, input int eat, input int win,
                     output int first, output int pulses);
    first = 0; pulses = 0;
    @(negedge clk); cyc_start = 1'b1; cyc_iack = iack; cyc_ext = ext;
    @(negedge clk); cyc_start = 1'b0;
    for (int j = 1; j <= win; j++) begin
      if (j == tat) begin
        rsp_ack = (tk == 1); rsp_err = (tk == 2); rsp_halt = (tk == 3); rsp_avec = (tk == 4);
      end
      if (j == eat) begin
        if (ek == 1) local_master = 1'b0;
        if (ek == 2) cyc_start = 1'b1;
        if (ek == 3) begin cfg_wr = 1'b1; cfg_ext_en = 1'b0; cfg_limit_sel = 2'b00; end
      end
      @(negedge clk);
      rsp_ack = 0; rsp_err = 0; rsp_halt = 0; rsp_avec = 0; cyc_start = 0; cfg_wr = 0;
      if (bus_err) begin pulses++; if (first == 0) first = j; end
    end
    local_master = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    int f, p;
    check(bus_err == 1'b0, "R1 reset bus_err", bus_err, 0);
    run(0, 0, 0, 0, 0, 0, 80, f, p);
    check(f == 64, "R1 default limit 64", f, 64);
    check(p == 1, "R8 single pulse", p, 1);
    run(0, 1, 0, 0, 0, 0, 80, f, p);
    check(f == 64, "R1 default ext enable", f, 64);
  endtask

  task automatic t_limits();
    int f, p;
    for (int s = 1; s < 4; s++) begin
      cfg_write(1'b1, 2'(s));
      run(0, 0, 0, 0, 0, 0, 80, f, p);
      check(f == exp_limit(2'(s)), "R2 R11 limit select", f, exp_limit(2'(s)));
      check(p == 1, "R8 one pulse per cycle", p, 1);
    end
  endtask

  task automatic t_terms();
    int f, p;
    cfg_write(1'b1, 2'b11);
    run(0, 0, 1, 8, 0, 0, 20, f, p); check(f == 0, "R3 ack at last edge", f, 0);
    run(0, 0, 2, 3, 0, 0, 20, f, p); check(f == 0, "R3 err response", f, 0);
    run(0, 0, 3, 8, 0, 0, 20, f, p); check(f == 0, "R3 halt response", f, 0);
    run(0, 0, 1, 9, 0, 0, 20, f, p); check(f == 8 && p == 1, "R8 late ack no second pulse", f, 8);
    run(1, 0, 4, 5, 0, 0, 20, f, p); check(f == 0, "R4 avec in iack", f, 0);
    run(0, 0, 4, 5, 0, 0, 20, f, p); check(f == 8, "R4 avec ignored in normal cycle", f, 8);
  endtask

  task automatic t_gating();
    int f, p;
    cfg_write(1'b1, 2'b11);
    run(0, 1, 0, 0, 0, 0, 20, f, p); check(f == 8, "R6 ext master enabled", f, 8);
    local_master = 1'b0;
    run(0, 1, 0, 0, 0, 0, 20, f, p); check(p == 0, "R6 ext not master", p, 0);
    run(0, 1, 0, 0, 1, 4, 20, f, p); check(p == 0, "R7 mastership lost", p, 0);
    run(0, 0, 0, 0, 1, 4, 20, f, p); check(f == 8, "R5 internal ignores mastership", f, 8);
    cfg_write(1'b0, 2'b11);
    run(0, 1, 0, 0, 0, 0, 20, f, p); check(p == 0, "R6 ext disabled", p, 0);
    local_master = 1'b0;
    run(0, 0, 0, 0, 0, 0, 20, f, p); check(f == 8, "R5 internal always", f, 8);
  endtask

  task automatic t_restart_cfg();
    int f, p;
    cfg_write(1'b1, 2'b11);
    run(0, 0, 0, 0, 2, 5, 30, f, p);
    check(f == 13 && p == 1, "R9 restart count", f, 13);
    run(0, 0, 0, 0, 3, 3, 20, f, p);
    check(f == 8, "R10 config latched at start", f, 8);
    run(0, 0, 0, 0, 0, 0, 80, f, p);
    check(f == 64, "R11 new limit next cycle", f, 64);
    run(0, 1, 0, 0, 0, 0, 80, f, p);
    check(p == 0, "R11 new enable next cycle", p, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      n_clk++;
      if (n_clk > 150000 && !done) begin
        done = 1;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", n_clk, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_limits();
    t_terms();
    t_gating();
    t_restart_cfg();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule